// File: doc/BRIEF.md
# Twin-Channel APB Timer Wrapper

This block is an APB slave that places two down-counting timer channels and a small set of block-level registers in one 4 KB address window. Each channel holds a reload value, a live count, a control byte and a raw interrupt flag. It counts on a prescaled tick and raises its interrupt when the count steps from one to zero. The wrapper decodes each access to one channel or to a block register. It adds an integration-test pair of registers that can take over the interrupt outputs, and it answers a fixed block of identification bytes.

Software programs a channel by writing its reload and control registers, then services the per-channel interrupt by writing that channel's clear register. The combined interrupt output serves an interrupt controller that has a single input for the whole block. For interconnect tests, setting the test-enable bit hands both channel interrupt outputs to a software-written register.

Top module: `twin_timer_apb`

## Requirements
- R1: After reset, both channels read CONTROL 0x20 (interrupt enabled, everything else clear), VALUE 0xFFFFFFFF and LOAD 0. The test-enable and test-output registers are 0, and all three interrupt outputs are low.
- R2: PREADY is always high and PSLVERR always low. A write takes effect at the clock edge on which PSEL, PENABLE and PWRITE are all high. PRDATA is valid during the access phase.
- R3: PADDR bit 5 picks the channel when PADDR[11:6] is zero. PADDR[4:2] picks the register inside it: 0 reload (LOAD), 1 count (VALUE), 2 CONTROL, 3 interrupt clear (write only), 4 raw status, 5 masked status, 6 background reload (BGLOAD). Only PADDR[11:2] is decoded.
- R4: A LOAD write sets both the reload value and the count. A BGLOAD write sets only the reload value. Both offsets read back the reload value.
- R5: CONTROL bit positions are: bit 7 run, bit 6 periodic (else free-running), bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit width (else 16-bit), bit 0 one-shot. Bit 4 and bits 31:8 read as zero.
- R6: While run is set, the count decrements once per tick. Prescale 0 gives a tick every clock, 1 every 16 clocks and 2 or 3 every 256 clocks. The first tick comes that many clocks after the enabling write.
- R7: The tick that takes the active count from 1 to 0 sets the raw flag. The masked status and the channel's interrupt output are the raw flag ANDed with interrupt enable. A write to the clear register drops the raw flag.
- R8: At a zero count, the next tick reloads the reload value in periodic mode or wraps to all ones of the active width in free-running mode. In 16-bit mode only bits 15:0 count, and bits 31:16 keep their value.
- R9: In one-shot mode a channel whose count is zero stays at zero.
- R10: Offset 0xF00 holds a readable test-enable bit (bit 0). While that bit is set, the channel 1 and channel 2 interrupt outputs follow bits 0 and 1 of the write-only test-output register at 0xF04, which reads as zero.
- R11: The combined interrupt output is high exactly when either channel interrupt output is high.
- R12: Offsets 0xFD0 to 0xFFC read, one byte per word in address order: 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R13: Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address in the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Ready, held high |
| pslverr | output | 1 | Error, held low |
| irq_ch1 | output | 1 | Channel 1 interrupt |
| irq_ch2 | output | 1 | Channel 2 interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
A write lands on the commit edge. Register contents and the interrupt pins are therefore sampled at the falling edge after that edge, and read data is sampled at the falling edge inside the access phase. Counter behaviour is timed from the commit edge of the enabling write. With prescale N, the tick that reaches zero comes N times the loaded count later, so the bench checks the interrupt pin one clock before and exactly on that edge (5, 32 and 256 clocks in the directed cases). When the bench stops a running channel with a back-to-back write, the ticks that happen up to and including that write's commit edge are counted into the expected VALUE.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

   // register slot inside one channel, decoded from PADDR[4:2]
   typedef enum logic [2:0] {
      RG_RELOAD   = 3'd0,
      RG_COUNT    = 3'd1,
      RG_CTRL     = 3'd2,
      RG_ACK      = 3'd3,
      RG_RAW      = 3'd4,
      RG_MASKED   = 3'd5,
      RG_BGRELOAD = 3'd6,
      RG_NONE     = 3'd7
   } tmr_reg_e;

   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       int_en;
      logic       rsvd;
      logic [1:0] prescale;
      logic       wide;
      logic       oneshot;
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);

   // word addresses (PADDR[11:2]) of the block-level registers
   localparam logic [9:0] WA_TEST_EN  = 10'h3C0;
   localparam logic [9:0] WA_TEST_OUT = 10'h3C1;
   localparam logic [9:0] WA_ID_FIRST = 10'h3F4;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV1_LOG2 = 4,
   parameter int DIV2_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int PRE_W = DIV2_LOG2;

   generate
      if (DIV1_LOG2 < 1 || DIV2_LOG2 <= DIV1_LOG2) begin : g_bad_div
         $error("tmr_prescaler: need 1 <= DIV1_LOG2 < DIV2_LOG2");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] limit;

   always_comb begin
      unique case (sel)
         2'd0:    limit = '0;
         2'd1:    limit = PRE_W'((1 << DIV1_LOG2) - 1);
         default: limit = '1;
      endcase
   end

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == limit) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import twin_timer_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int NARROW_W  = 16,
   parameter int DIV1_LOG2 = 4,
   parameter int DIV2_LOG2 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  tmr_reg_e         reg_sel,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq_masked,
   output logic             running
);
   generate
      if (CNT_W < CTRL_W || NARROW_W > CNT_W || NARROW_W < 1) begin : g_bad_w
         $error("tmr_channel: need CTRL_W <= CNT_W and 1 <= NARROW_W <= CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q, cnt_q;
   tmr_ctrl_t        ctrl_q;
   logic             raw_q;
   logic             tick;
   logic [CNT_W-1:0] act_mask, act, nxt;
   logic             hit;

   tmr_prescaler #(.DIV1_LOG2(DIV1_LOG2), .DIV2_LOG2(DIV2_LOG2)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_q.run),
      .sel  (ctrl_q.prescale),
      .tick (tick)
   );

   // active-width mask: narrow mode counts only the low bits
   generate
      if (NARROW_W == CNT_W) begin : g_same_w
         assign act_mask = '1;
      end else begin : g_two_w
         assign act_mask = ctrl_q.wide ? '1
                         : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      end
   endgenerate

   assign act = cnt_q & act_mask;

   always_comb begin
      nxt = act;
      hit = 1'b0;
      if (act != '0) begin
         nxt = act - 1'b1;
         hit = (act == CNT_W'(1));
      end else if (!ctrl_q.oneshot) begin
         nxt = ctrl_q.periodic ? (reload_q & act_mask) : act_mask;
      end
   end

   logic wr_reload, wr_bg, wr_ctrl, wr_ack;
   assign wr_reload = wr_stb && reg_sel == RG_RELOAD;
   assign wr_bg     = wr_stb && reg_sel == RG_BGRELOAD;
   assign wr_ctrl   = wr_stb && reg_sel == RG_CTRL;
   assign wr_ack    = wr_stb && reg_sel == RG_ACK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '1;
         ctrl_q   <= '{run: 1'b0, periodic: 1'b0, int_en: 1'b1, rsvd: 1'b0,
                       prescale: 2'd0, wide: 1'b0, oneshot: 1'b0};
         raw_q    <= 1'b0;
      end else begin
         if (wr_reload || wr_bg) begin
            reload_q <= wdata;
         end
         if (wr_reload) begin
            cnt_q <= wdata;
         end else if (tick) begin
            cnt_q <= (cnt_q & ~act_mask) | (nxt & act_mask);
         end
         if (wr_ctrl) begin
            ctrl_q      <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
            ctrl_q.rsvd <= 1'b0;
         end
         if (tick && hit && !wr_reload) begin
            raw_q <= 1'b1;
         end else if (wr_ack) begin
            raw_q <= 1'b0;
         end
      end
   end

   assign irq_masked = raw_q && ctrl_q.int_en;
   assign running    = ctrl_q.run;

   always_comb begin
      unique case (reg_sel)
         RG_RELOAD,
         RG_BGRELOAD: rdata = reload_q;
         RG_COUNT:    rdata = cnt_q;
         RG_CTRL:     rdata = CNT_W'(ctrl_q);
         RG_RAW:      rdata = CNT_W'(raw_q);
         RG_MASKED:   rdata = CNT_W'(irq_masked);
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/twin_timer_id.sv
module twin_timer_id (
   input  logic [3:0] slot,
   output logic [7:0] id_byte
);
   // slot counts words upward from the first identification word
   always_comb begin
      unique case (slot)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = 8'h23;
         4'd5:    id_byte = 8'hB8;
         4'd6:    id_byte = 8'h1B;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hF0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   end
endmodule

// File: rtl/twin_timer_apb.sv
module twin_timer_apb
   import twin_timer_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NARROW_W  = 16,
   parameter int DIV1_LOG2 = 4,
   parameter int DIV2_LOG2 = 8
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              irq_ch1,
   output logic              irq_ch2,
   output logic              irq_any
);
   localparam int NCH     = 2;
   localparam int WORD_W  = 10;
   localparam int TEST_W  = NCH;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("twin_timer_apb: ADDR_W must cover a 4 KB window");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("twin_timer_apb: DATA_W must hold a control byte");
      end
   endgenerate

   logic [WORD_W-1:0] wa;
   logic              in_chan, is_test_en, is_test_out, is_id;
   logic              ch_idx;
   tmr_reg_e          ch_reg;
   logic              wr_commit;

   assign wa          = paddr[11:2];
   assign in_chan     = (wa[9:4] == '0);
   assign ch_idx      = wa[3];
   assign ch_reg      = tmr_reg_e'(wa[2:0]);
   assign is_test_en  = (wa == WA_TEST_EN);
   assign is_test_out = (wa == WA_TEST_OUT);
   assign is_id       = (wa >= WA_ID_FIRST);
   assign wr_commit   = psel && penable && pwrite;

   logic [DATA_W-1:0] ch_rdata [NCH];
   logic [NCH-1:0]    ch_irq;
   logic [NCH-1:0]    ch_run;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmr_channel #(
         .CNT_W    (DATA_W),
         .NARROW_W (NARROW_W),
         .DIV1_LOG2(DIV1_LOG2),
         .DIV2_LOG2(DIV2_LOG2)
      ) u_ch (
         .clk       (pclk),
         .rst_n     (presetn),
         .wr_stb    (wr_commit && in_chan && (ch_idx == 1'(i))),
         .reg_sel   (ch_reg),
         .wdata     (pwdata),
         .rdata     (ch_rdata[i]),
         .irq_masked(ch_irq[i]),
         .running   (ch_run[i])
      );
   end

   logic              test_en_q;
   logic [TEST_W-1:0] test_out_q;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         test_en_q  <= 1'b0;
         test_out_q <= '0;
      end else if (wr_commit) begin
         if (is_test_en)  test_en_q  <= pwdata[0];
         if (is_test_out) test_out_q <= pwdata[TEST_W-1:0];
      end
   end

   logic [7:0] id_byte;
   twin_timer_id u_id (
      .slot   (wa[3:0] - 4'd4),
      .id_byte(id_byte)
   );

   always_comb begin
      prdata = '0;
      if (in_chan) begin
         prdata = ch_rdata[ch_idx];
      end else if (is_test_en) begin
         prdata = DATA_W'(test_en_q);
      end else if (is_id) begin
         prdata = DATA_W'(id_byte);
      end
   end

   logic [NCH-1:0] irq_vec;
   assign irq_vec = test_en_q ? test_out_q : ch_irq;
   assign irq_ch1 = irq_vec[0];
   assign irq_ch2 = irq_vec[1];
   assign irq_any = |irq_vec;

   assign pready  = 1'b1;
   assign pslverr = 1'b0;
endmodule

// File: rtl/twin_timer_apb_chk.sv
module twin_timer_apb_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic [DATA_W-1:0] prdata,
   input logic              irq_ch1,
   input logic              irq_ch2,
   input logic              irq_any,
   input logic              test_en_q,
   input logic [1:0]        ch_run
);
   logic [9:0] wa;
   logic       commit;
   assign wa     = paddr[11:2];
   assign commit = psel && penable && pwrite;

   // R1
   reset_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(presetn) |-> !irq_any);

   // R10
   test_drive_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (commit && wa == 10'h3C1 && test_en_q)
      |=> (irq_ch1 == $past(pwdata[0]) && irq_ch2 == $past(pwdata[1])));

   // R10
   test_out_read_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && wa == 10'h3C1) |-> (prdata == '0));

   // R12
   id_write_ignored_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (commit && wa >= 10'h3F4) |=> $stable(test_en_q));

   // R7
   stopped_irq_stable_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (!ch_run[0] && !test_en_q && !(commit && wa[9:3] == 7'd0) && !(commit && wa == 10'h3C0))
      |=> $stable(irq_ch1));
endmodule

bind twin_timer_apb twin_timer_apb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .pclk     (pclk),
   .presetn  (presetn),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .prdata   (prdata),
   .irq_ch1  (irq_ch1),
   .irq_ch2  (irq_ch2),
   .irq_any  (irq_any),
   .test_en_q(test_en_q),
   .ch_run   (ch_run)
);

// File: tb/twin_timer_apb_tb.sv
`timescale 1ns/1ps
module twin_timer_apb_tb;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rstn = 1'b0;
   logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [DATA_W-1:0] pwdata = '0;
   logic [DATA_W-1:0] prdata;
   logic              pready, pslverr, irq1, irq2, irqc;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   twin_timer_apb u_dut (
      .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr),
      .irq_ch1(irq1), .irq_ch2(irq2), .irq_any(irqc)
   );

   function automatic logic [7:0] id_exp(input int k);
      case (k)
         0: return 8'h04;  4: return 8'h23;  5: return 8'hB8;  6: return 8'h1B;
         8: return 8'h0D;  9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; commits at the second rising edge after it
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(posedge clk);
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk); penable = 1;
      d = prdata;
      @(posedge clk);
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rl [2];
      logic [31:0] cv [2];
      logic [31:0] v;
      void'($urandom(32'h5EED_7100));
      repeat (3) @(posedge clk);
      @(negedge clk); rstn = 1;
      @(negedge clk);

      // R1 reset values
      chk("R1 irq_any", {31'b0, irqc}, 0);
      chk("R1 irq_ch1", {31'b0, irq1}, 0);
      rchk("R1 ctrl ch1", 12'h008, 32'h20);
      rchk("R1 value ch2", 12'h024, 32'hFFFF_FFFF);
      rchk("R1 load ch1", 12'h000, 0);
      rchk("R1 test_en", 12'hF00, 0);
      // R2 no wait states, no error
      psel = 1; paddr = 12'h008; @(negedge clk); penable = 1;
      chk("R2 ready/err", {30'b0, pready, pslverr}, 32'h2);
      @(posedge clk); @(negedge clk); psel = 0; penable = 0;

      // R4 R3 random reload traffic on stopped channels
      rl[0] = 0; rl[1] = 0; cv[0] = '1; cv[1] = '1;
      for (int i = 0; i < 24; i++) begin
         int c = $urandom % 2;
         logic [31:0] d = $urandom;
         logic [11:0] base = c ? 12'h020 : 12'h000;
         if ($urandom % 2) begin wr(base, d); rl[c] = d; cv[c] = d; end
         else begin wr(base + 12'h018, d); rl[c] = d; end
         rchk("R4 reload", base, rl[c]);
         rchk("R4 bgreload", base + 12'h018, rl[c]);
         rchk("R3 count", base + 12'h004, cv[c]);
         rchk("R3 other ch", (c ? 12'h000 : 12'h020) + 12'h004, cv[1-c]);
      end

      // R5 control layout, bit 4 and upper bits dropped
      wr(12'h008, 32'hFFFF_FF5E);
      rchk("R5 ctrl readback", 12'h008, 32'h4E);
      wr(12'h008, 32'h20);

      // R6 R7 R8 periodic, prescale 1 clock, load 5
      wr(12'h000, 5);
      wr(12'h008, 32'hE0);
      wait_n(4);
      chk("R7 irq before zero", {31'b0, irq1}, 0);
      wait_n(1);
      chk("R7 irq at zero", {31'b0, irq1}, 1);
      chk("R11 any follows ch1", {31'b0, irqc}, 1);
      wr(12'h008, 32'h60);             // ticks: 0->5, 5->4
      rchk("R8 periodic reload", 12'h004, 4);
      rchk("R7 raw", 12'h010, 1);
      wr(12'h00C, 0);
      chk("R7 clear", {31'b0, irq1}, 0);
      rchk("R7 raw cleared", 12'h010, 0);

      // R6 prescale 16
      wr(12'h000, 2);
      wr(12'h008, 32'hE4);
      wait_n(31);
      chk("R6 div16 early", {31'b0, irq1}, 0);
      wait_n(1);
      chk("R6 div16 on time", {31'b0, irq1}, 1);
      wr(12'h008, 32'h64);
      wr(12'h00C, 0);

      // R6 prescale code 3 behaves as 256
      wr(12'h000, 1);
      wr(12'h008, 32'hEC);
      wait_n(255);
      chk("R6 div256 early", {31'b0, irq1}, 0);
      wait_n(1);
      chk("R6 div256 on time", {31'b0, irq1}, 1);
      wr(12'h008, 32'h6C);
      wr(12'h00C, 0);

      // R8 free-running 16-bit wrap keeps upper half
      wr(12'h008, 32'h20);
      wr(12'h000, 32'h0003_0002);
      wr(12'h008, 32'hA0);
      wait_n(1);
      wr(12'h008, 32'h20);             // three ticks: 2,1,0 -> FFFF
      rchk("R8 16-bit wrap", 12'h004, 32'h0003_FFFF);
      wr(12'h00C, 0);

      // R9 one-shot holds at zero
      wr(12'h000, 2);
      wr(12'h008, 32'hE1);
      wait_n(6);
      wr(12'h008, 32'h61);
      rchk("R9 oneshot hold", 12'h004, 0);
      wr(12'h00C, 0);

      // R7 masking on channel 2, 32-bit free-running
      wr(12'h020, 1);
      wr(12'h028, 32'h82);
      wr(12'h028, 32'h02);
      rchk("R7 ch2 raw", 12'h030, 1);
      rchk("R7 ch2 masked off", 12'h034, 0);
      chk("R7 ch2 pin masked", {31'b0, irq2}, 0);
      wr(12'h028, 32'h22);
      chk("R7 ch2 pin enabled", {31'b0, irq2}, 1);
      chk("R11 any follows ch2", {31'b0, irqc}, 1);
      rchk("R8 32-bit wrap", 12'h024, 32'hFFFF_FFFF);
      wr(12'h02C, 0);
      chk("R7 ch2 cleared", {31'b0, irq2}, 0);

      // R12 identification words
      for (int k = 0; k < 12; k++) rchk("R12 id", 12'hFD0 + 12'(4 * k), {24'b0, id_exp(k)});
      wr(12'hFE0, 32'hFF);
      rchk("R12 id after write", 12'hFE0, 32'h23);

      // R13 unmapped space
      wr(12'h01C, 32'h1234);
      wr(12'h040, 32'h5678);
      rchk("R13 slot7 zero", 12'h01C, 0);
      rchk("R13 gap zero", 12'h040, 0);
      rchk("R13 far zero", 12'h800, 0);
      rchk("R13 ch1 untouched", 12'h000, 2);
      rchk("R3 byte alias", 12'h00A, 32'h61);

      // R10 R11 test mode with random patterns
      wr(12'hF00, 1);
      rchk("R10 test_en read", 12'hF00, 1);
      for (int i = 0; i < 12; i++) begin
         logic [1:0] p = 2'($urandom);
         wr(12'hF04, {30'b0, p});
         chk("R10 pin1", {31'b0, irq1}, {31'b0, p[0]});
         chk("R10 pin2", {31'b0, irq2}, {31'b0, p[1]});
         chk("R11 any", {31'b0, irqc}, {31'b0, |p});
      end
      rchk("R10 test_out reads zero", 12'hF04, 0);
      wr(12'hF04, 3);
      wr(12'hF00, 0);
      chk("R10 back to channels", {31'b0, irqc}, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule